// File: doc/BRIEF.md
# Multi-Pipe Buffer Read Port with Rewind

This block is the processor-facing read port of a packet-buffer endpoint controller. It owns a set of pipes. Each pipe has a receive buffer split into two equal sides, so one side can be filled from the link while software drains the other. A configuration write picks the pipe the port serves, and sets the access width (one byte or two bytes per read), the byte order of a two-byte read, the automatic-clear policy and whether a DMA request is raised. Each read strobe returns the data at the current read position and moves the position forward.

The port keeps a separate read position for every pipe. Software can select another pipe in the middle of a packet and later come back to the place where it stopped. A rewind command, given in a configuration write that keeps the same pipe, sets the read position of the side being drained back to its first byte, so the packet can be read again. Sides are released to the filler when a full-size packet has been read to the end, when software issues a clear, or, with automatic clearing, when a short packet has been read to its last byte. With automatic clearing, a zero-length packet that arrives for the selected, empty pipe is dropped.

A fill interface stands in for the link side. It pushes bytes into a pipe, and an end strobe closes the packet.

Top module: `pfp_port`

## Requirements
- R1: After reset, `port_ready` and `dma_req` are 0 and `cur_pipe` is 0.
- R2: In byte mode, `rd_data[7:0]` shows the byte at the read position of the selected pipe's current side and `rd_data[15:8]` is 0. Each `rd_en` moves the position on by one. `port_ready` stays high while there is no read, no clear and no configuration write.
- R3: In two-byte mode (`cfg_wide`=1), `rd_data` holds the byte at the read position and the byte after it. The earlier byte goes in bits [7:0] when `cfg_bigend`=0 and in bits [15:8] when `cfg_bigend`=1. Each `rd_en` moves the position on by two.
- R4: A configuration write with `cfg_rewind`=1 and `cfg_pipe` equal to `cur_pipe`, made while `port_ready` is 1, sets the read position to 0 from the next cycle.
- R5: A rewind acts once for each write that carries it. Reads made after it move the position on as normal.
- R6: Each pipe keeps its own read position. Selecting another pipe and then selecting the first one again resumes at the saved position.
- R7: A configuration write that carries `cfg_rewind`=1 and also changes the pipe does not rewind either pipe.
- R8: When the last byte of a full packet (SIDE_BYTES bytes) is read, that side is released and the pipe moves to its other side. If the other side holds a packet, `port_ready` stays 1 and its first byte is shown.
- R9: A rewind on a pipe that has moved to its second side restarts that side and does not bring back data from the released side.
- R10: `buf_clr` releases the selected pipe's current side. `port_ready` then follows the other side: 0 if it is empty, 1 if it holds a packet.
- R11: A short packet that has been read to its end stays held, with `port_ready`=1, unless both `cfg_autoclr` and `cfg_rdend` are 1. In that case the side is released after its last byte is read.
- R12: A zero-length packet (`fill_end` with no bytes pushed) for the selected pipe is dropped when `cfg_autoclr`=1 and the pipe holds no packet. With `cfg_autoclr`=0 it is kept as a packet, and `port_ready` becomes 1.
- R13: `dma_req` is 1 only while `cfg_dma_en` was set by the last configuration write and `port_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pipe | input | $clog2(NUM_PIPES) | Pipe to select |
| cfg_rewind | input | 1 | Rewind request, acts only on the write cycle |
| cfg_autoclr | input | 1 | Automatic clear enable |
| cfg_rdend | input | 1 | Release a short packet when it has been read to its end |
| cfg_dma_en | input | 1 | DMA request enable |
| cfg_wide | input | 1 | Two-byte access when 1 |
| cfg_bigend | input | 1 | Big-endian byte order for two-byte access |
| buf_clr | input | 1 | Release the current side of the selected pipe |
| rd_en | input | 1 | Read strobe, advances the read position |
| rd_data | output | 16 | Data at the read position |
| port_ready | output | 1 | Selected pipe has a packet to read |
| dma_req | output | 1 | DMA request |
| cur_pipe | output | $clog2(NUM_PIPES) | Currently selected pipe |
| fill_we | input | 1 | Push one byte into a pipe |
| fill_pipe | input | $clog2(NUM_PIPES) | Pipe being filled |
| fill_byte | input | 8 | Byte being pushed |
| fill_end | input | 1 | Close the packet being filled |

## Verification
The hardest case to reach is a rewind on the second side of a double-buffered pipe. The bench first has to queue a full-size packet and a short packet on one pipe, then drain all SIDE_BYTES bytes of the first packet so the hardware moves to the other side by itself. Only then does it read into the short packet and issue the rewind, expecting that packet's first byte rather than the released one. Pipe switching gets the same careful treatment: the bench parks one pipe part-way through a packet, switches away with a rewind attached to the switch, reads elsewhere, and returns to check that the saved position was not disturbed.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

    typedef struct packed {
        logic autoclr;
        logic rdend;
        logic dma_en;
        logic wide;
        logic bigend;
    } port_cfg_t;

    function automatic logic [15:0] pack_word(input logic [7:0] first,
                                              input logic [7:0] second,
                                              input logic       wide,
                                              input logic       bigend);
        if (!wide)
            return {8'h00, first};
        else if (bigend)
            return {first, second};
        else
            return {second, first};
    endfunction

endpackage

// File: rtl/pfp_buf_mem.sv
module pfp_buf_mem #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr0,
    input  logic [AW-1:0] raddr1,
    output logic [7:0]    rdata0,
    output logic [7:0]    rdata1
);
    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            store[waddr] <= wdata;
    end

    assign rdata0 = store[raddr0];
    assign rdata1 = store[raddr1];
endmodule

// File: rtl/pfp_pipe_ctx.sv
module pfp_pipe_ctx #(
    parameter int SIDE_BYTES = 32,
    parameter int CW         = $clog2(SIDE_BYTES) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic [1:0]    rd_step,
    input  logic          rewind,
    input  logic          clr,
    input  logic          rel_short,
    input  logic          zlp_drop_en,
    input  logic          fill_we,
    input  logic          fill_end,
    output logic          ready,
    output logic          rd_side,
    output logic [CW-1:0] rd_ptr,
    output logic          wr_side,
    output logic [CW-1:0] wr_cnt,
    output logic          fill_ok
);
    logic [1:0]    full_q;
    logic [CW-1:0] cnt_q [2];
    logic [CW-1:0] ptr_q;
    logic [CW-1:0] wcnt_q;
    logic          rs_q;
    logic          ws_q;

    logic [CW:0]   sum;
    logic [CW-1:0] nptr;
    logic          release_now;
    logic          zlp_drop;

    assign ready    = full_q[rs_q];
    assign fill_ok  = !full_q[ws_q] && (wcnt_q < CW'(SIDE_BYTES));
    assign zlp_drop = zlp_drop_en && (wcnt_q == '0) && !ready;

    always_comb begin
        sum  = {1'b0, ptr_q} + (CW+1)'(rd_step);
        nptr = (sum > {1'b0, cnt_q[rs_q]}) ? cnt_q[rs_q] : sum[CW-1:0];
        release_now = 1'b0;
        if (sel && ready && !rewind) begin
            if (clr)
                release_now = 1'b1;
            else if (rd_step != 2'd0 && nptr == cnt_q[rs_q] &&
                     (cnt_q[rs_q] == CW'(SIDE_BYTES) || rel_short))
                release_now = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q   <= '0;
            cnt_q[0] <= '0;
            cnt_q[1] <= '0;
            ptr_q    <= '0;
            wcnt_q   <= '0;
            rs_q     <= 1'b0;
            ws_q     <= 1'b0;
        end else begin
            // filler side: only ever touches the side that is not full
            if (fill_end && !full_q[ws_q]) begin
                wcnt_q <= '0;
                if (!zlp_drop) begin
                    full_q[ws_q] <= 1'b1;
                    cnt_q[ws_q]  <= wcnt_q;
                    ws_q         <= ~ws_q;
                end
            end else if (fill_we && fill_ok) begin
                wcnt_q <= wcnt_q + CW'(1);
            end
            // reader side: only ever releases the side that is full
            if (release_now) begin
                full_q[rs_q] <= 1'b0;
                cnt_q[rs_q]  <= '0;
                rs_q         <= ~rs_q;
                ptr_q        <= '0;
            end else if (sel) begin
                if (rewind && ready)
                    ptr_q <= '0;
                else if (clr)
                    ptr_q <= '0;
                else if (rd_step != 2'd0 && ready)
                    ptr_q <= nptr;
            end
        end
    end

    assign rd_side = rs_q;
    assign rd_ptr  = ptr_q;
    assign wr_side = ws_q;
    assign wr_cnt  = wcnt_q;
endmodule

// File: rtl/pfp_port.sv
module pfp_port
    import pfp_pkg::*;
#(
    parameter int NUM_PIPES  = 8,
    parameter int SIDE_BYTES = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [$clog2(NUM_PIPES)-1:0] cfg_pipe,
    input  logic                         cfg_rewind,
    input  logic                         cfg_autoclr,
    input  logic                         cfg_rdend,
    input  logic                         cfg_dma_en,
    input  logic                         cfg_wide,
    input  logic                         cfg_bigend,
    input  logic                         buf_clr,
    input  logic                         rd_en,
    output logic [15:0]                  rd_data,
    output logic                         port_ready,
    output logic                         dma_req,
    output logic [$clog2(NUM_PIPES)-1:0] cur_pipe,
    input  logic                         fill_we,
    input  logic [$clog2(NUM_PIPES)-1:0] fill_pipe,
    input  logic [7:0]                   fill_byte,
    input  logic                         fill_end
);
    localparam int PW    = $clog2(NUM_PIPES);
    localparam int IW    = $clog2(SIDE_BYTES);
    localparam int CW    = IW + 1;
    localparam int AW    = PW + 1 + IW;
    localparam int DEPTH = NUM_PIPES * 2 * SIDE_BYTES;

    logic [PW-1:0] cur_q;
    port_cfg_t     cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            cfg_q <= '0;
        end else if (cfg_we) begin
            cur_q <= cfg_pipe;
            cfg_q <= '{autoclr: cfg_autoclr, rdend: cfg_rdend, dma_en: cfg_dma_en,
                       wide: cfg_wide, bigend: cfg_bigend};
        end
    end

    logic       rewind_cmd;
    logic [1:0] step;
    assign rewind_cmd = cfg_we && cfg_rewind && (cfg_pipe == cur_q);
    assign step       = rd_en ? (cfg_q.wide ? 2'd2 : 2'd1) : 2'd0;

    logic          rdy [NUM_PIPES];
    logic          rs  [NUM_PIPES];
    logic [CW-1:0] ptr [NUM_PIPES];
    logic          ws  [NUM_PIPES];
    logic [CW-1:0] wc  [NUM_PIPES];
    logic          fok [NUM_PIPES];

    for (genvar g = 0; g < NUM_PIPES; g++) begin : g_pipe
        logic sel_g;
        logic fill_g;
        assign sel_g  = (cur_q == PW'(g));
        assign fill_g = (fill_pipe == PW'(g));
        pfp_pipe_ctx #(.SIDE_BYTES(SIDE_BYTES)) u_ctx (
            .clk         (clk),
            .rst         (rst),
            .sel         (sel_g),
            .rd_step     (step),
            .rewind      (rewind_cmd),
            .clr         (buf_clr),
            .rel_short   (cfg_q.autoclr && cfg_q.rdend),
            .zlp_drop_en (cfg_q.autoclr && sel_g),
            .fill_we     (fill_we && fill_g),
            .fill_end    (fill_end && fill_g),
            .ready       (rdy[g]),
            .rd_side     (rs[g]),
            .rd_ptr      (ptr[g]),
            .wr_side     (ws[g]),
            .wr_cnt      (wc[g]),
            .fill_ok     (fok[g])
        );
    end

    logic [AW-1:0] wbase, rbase, waddr, raddr0, raddr1;
    logic [7:0]    b0, b1;
    logic          mem_we;

    assign wbase  = {fill_pipe, ws[fill_pipe], {IW{1'b0}}};
    assign waddr  = wbase + AW'(wc[fill_pipe]);
    assign mem_we = fill_we && fok[fill_pipe];
    assign rbase  = {cur_q, rs[cur_q], {IW{1'b0}}};
    assign raddr0 = rbase + AW'(ptr[cur_q]);
    assign raddr1 = raddr0 + AW'(1);

    pfp_buf_mem #(.DEPTH(DEPTH)) u_mem (
        .clk    (clk),
        .we     (mem_we),
        .waddr  (waddr),
        .wdata  (fill_byte),
        .raddr0 (raddr0),
        .raddr1 (raddr1),
        .rdata0 (b0),
        .rdata1 (b1)
    );

    assign port_ready = rdy[cur_q];
    assign dma_req    = cfg_q.dma_en && port_ready;
    assign cur_pipe   = cur_q;
    assign rd_data    = pack_word(b0, b1, cfg_q.wide, cfg_q.bigend);
endmodule

// File: rtl/pfp_port_chk.sv
module pfp_port_chk #(
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [PW-1:0] cfg_pipe,
    input logic          cfg_rewind,
    input logic          cfg_dma_en,
    input logic          buf_clr,
    input logic          rd_en,
    input logic          port_ready,
    input logic          dma_req,
    input logic [PW-1:0] cur_pipe
);
    AST_DMA_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> port_ready); // R13

    AST_DMA_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_dma_en) |=> !dma_req); // R13

    AST_PIPE_HELD: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cur_pipe)); // R6

    AST_REWIND_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_rewind && cfg_pipe == cur_pipe && port_ready) |=> port_ready); // R4

    AST_READY_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (port_ready && !rd_en && !buf_clr && !cfg_we) |=> port_ready); // R2
endmodule

bind pfp_port pfp_port_chk #(.PW($clog2(NUM_PIPES))) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_pipe   (cfg_pipe),
    .cfg_rewind (cfg_rewind),
    .cfg_dma_en (cfg_dma_en),
    .buf_clr    (buf_clr),
    .rd_en      (rd_en),
    .port_ready (port_ready),
    .dma_req    (dma_req),
    .cur_pipe   (cur_pipe)
);

// File: tb/tb_pfp_port.sv
module tb_pfp_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 0, cfg_rewind = 0, cfg_autoclr = 0, cfg_rdend = 0;
    logic        cfg_dma_en = 0, cfg_wide = 0, cfg_bigend = 0;
    logic [2:0]  cfg_pipe = 0;
    logic        buf_clr = 0, rd_en = 0;
    logic [15:0] rd_data;
    logic        port_ready, dma_req;
    logic [2:0]  cur_pipe;
    logic        fill_we = 0, fill_end = 0;
    logic [2:0]  fill_pipe = 0;
    logic [7:0]  fill_byte = 0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pfp_port dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_pipe(cfg_pipe),
        .cfg_rewind(cfg_rewind), .cfg_autoclr(cfg_autoclr), .cfg_rdend(cfg_rdend),
        .cfg_dma_en(cfg_dma_en), .cfg_wide(cfg_wide), .cfg_bigend(cfg_bigend),
        .buf_clr(buf_clr), .rd_en(rd_en), .rd_data(rd_data), .port_ready(port_ready),
        .dma_req(dma_req), .cur_pipe(cur_pipe), .fill_we(fill_we),
        .fill_pipe(fill_pipe), .fill_byte(fill_byte), .fill_end(fill_end)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] p, input logic rew, input logic ac,
                       input logic re, input logic dma, input logic wide, input logic be);
        @(negedge clk);
        cfg_we = 1; cfg_pipe = p; cfg_rewind = rew; cfg_autoclr = ac;
        cfg_rdend = re; cfg_dma_en = dma; cfg_wide = wide; cfg_bigend = be;
        @(negedge clk);
        cfg_we = 0; cfg_rewind = 0;
    endtask

    task automatic push(input logic [2:0] p, input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fill_we = 1; fill_pipe = p; fill_byte = base + 8'(i);
        end
        @(negedge clk);
        fill_we = 0; fill_end = 1; fill_pipe = p;
        @(negedge clk);
        fill_end = 0;
    endtask

    task automatic pop();
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic clear();
        @(negedge clk); buf_clr = 1;
        @(negedge clk); buf_clr = 0;
    endtask

    task automatic t_reset();
        chk("R1 ready", 16'(port_ready), 16'h0);
        chk("R1 dma", 16'(dma_req), 16'h0);
        chk("R1 pipe", 16'(cur_pipe), 16'h0);
    endtask

    task automatic t_narrow();
        push(3'd0, 4, 8'h10);
        cfg(3'd0, 0, 0, 0, 0, 0, 0);
        chk("R2 ready", 16'(port_ready), 16'h1);
        chk("R2 first byte", rd_data, 16'h0010);
        pop();
        chk("R2 advance", rd_data, 16'h0011);
        pop();
    endtask

    task automatic t_wide();
        cfg(3'd0, 0, 0, 0, 0, 1, 0);
        chk("R3 little endian", rd_data, 16'h1312);
        cfg(3'd0, 0, 0, 0, 0, 1, 1);
        chk("R3 big endian", rd_data, 16'h1213);
        cfg(3'd0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_rewind();
        cfg(3'd0, 1, 0, 0, 0, 0, 0);
        chk("R4 rewind to start", rd_data, 16'h0010);
        pop();
        chk("R5 reads advance after rewind", rd_data, 16'h0011);
    endtask

    task automatic t_switch();
        push(3'd1, 4, 8'h20);
        cfg(3'd1, 1, 0, 0, 0, 0, 0);
        chk("R6 switched pipe", 16'(cur_pipe), 16'h1);
        chk("R7 pipe1 start", rd_data, 16'h0020);
        pop();
        chk("R6 pipe1 advance", rd_data, 16'h0021);
        cfg(3'd0, 0, 0, 0, 0, 0, 0);
        chk("R7 pipe0 not rewound", rd_data, 16'h0011);
        cfg(3'd1, 0, 0, 0, 0, 0, 0);
        chk("R6 pipe1 resumed", rd_data, 16'h0021);
    endtask

    task automatic t_double();
        push(3'd2, 32, 8'h40);
        push(3'd2, 2, 8'h80);
        cfg(3'd2, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 32; i++) pop();
        chk("R8 ready after full packet", 16'(port_ready), 16'h1);
        chk("R8 second side shown", rd_data, 16'h0080);
        pop();
        chk("R8 second side advance", rd_data, 16'h0081);
        cfg(3'd2, 1, 0, 0, 0, 0, 0);
        chk("R9 rewind on second side", rd_data, 16'h0080);
        clear();
        chk("R10 clear drops ready", 16'(port_ready), 16'h0);
    endtask

    task automatic t_clear_two();
        push(3'd3, 3, 8'h30);
        push(3'd3, 2, 8'h50);
        cfg(3'd3, 0, 0, 0, 0, 0, 0);
        clear();
        chk("R10 ready from other side", 16'(port_ready), 16'h1);
        chk("R10 other side data", rd_data, 16'h0050);
        clear();
        chk("R10 both released", 16'(port_ready), 16'h0);
    endtask

    task automatic t_short();
        push(3'd4, 3, 8'h60);
        cfg(3'd4, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) pop();
        chk("R11 short held", 16'(port_ready), 16'h1);
        clear();
        cfg(3'd4, 0, 1, 1, 0, 0, 0);
        push(3'd4, 3, 8'h70);
        chk("R11 short ready", 16'(port_ready), 16'h1);
        chk("R11 short data", rd_data, 16'h0070);
        for (int i = 0; i < 3; i++) pop();
        chk("R11 short auto released", 16'(port_ready), 16'h0);
    endtask

    task automatic t_zlp();
        push(3'd4, 0, 8'h00);
        chk("R12 zlp dropped", 16'(port_ready), 16'h0);
        cfg(3'd5, 0, 0, 0, 0, 0, 0);
        push(3'd5, 0, 8'h00);
        chk("R12 zlp kept", 16'(port_ready), 16'h1);
        clear();
    endtask

    task automatic t_dma();
        cfg(3'd6, 0, 0, 0, 1, 0, 0);
        chk("R13 no data no request", 16'(dma_req), 16'h0);
        push(3'd6, 2, 8'h90);
        chk("R13 request with data", 16'(dma_req), 16'h1);
        cfg(3'd6, 0, 0, 0, 0, 0, 0);
        chk("R13 request disabled", 16'(dma_req), 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_narrow();
        t_wide();
        t_rewind();
        t_switch();
        t_double();
        t_clear_two();
        t_short();
        t_zlp();
        t_dma();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule